// File: doc/BRIEF.md
# Hierarchical Interrupt Status Encoder

This block gathers three groups of interrupt request lines (a small critical group, a main group and a peripheral group) and reduces each group to one winning source number. The three results are packed, together with a valid flag per group, into a single 32-bit status word. Software reads this word to find the interrupt it must service next. Inside each group the lowest-numbered active, enabled source wins.

Two group levels forward work to the peripheral group. Critical code 2 is raised whenever an enabled peripheral source that is classed as high priority is active. Main code 4 is raised whenever an enabled peripheral source outside that class is active. Peripheral source 0 carries the cascaded DMA controller request. The main and peripheral groups have disable masks, where a 1 disables a source. The masks sit behind a small register port with one select bit. The status word is registered and is refreshed on every clock.

Top module: `irq_status_enc`

## Requirements
- R1: After reset the status word is 0x00000000. The main mask reads 0x00010fff (select 0) and the peripheral mask reads 0x7ffffc00 (select 1), so every maskable source starts disabled.
- R2: Status bit 10 is the critical valid flag and bits 9:8 give the lowest active critical line. Critical lines 0, 1 and 3 have no mask.
- R3: Status bit 21 is the main valid flag and bits 20:16 give the lowest active, enabled main source. Main source n is disabled by main mask bit 16-n when that bit is set. Sources 1 to 4 have no mask bit.
- R4: Status bit 29 is the peripheral valid flag and bits 28:24 give the lowest active, enabled peripheral source (0 to 21). Source n is disabled by peripheral mask bit 31-n. Source 0, the DMA cascade, has no mask bit.
- R5: The critical input line 2 is ignored. Critical code 2 is requested when any active, enabled peripheral source in the high-priority set (sources 1 and 2, set 0x00000006) is present.
- R6: The main input line 4 is ignored. Main code 4 is requested when any active, enabled peripheral source outside the high-priority set is present.
- R7: The status word reflects the inputs and masks sampled at the previous rising clock edge. Bits outside the three fields always read 0.
- R8: Mask writes take effect from the following clock edge. Mask bits with no source behind them read 0 and ignore writes.
- R9: A group whose valid flag is 0 reports source number 0.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crit_src | input | 4 | Critical request lines, active high |
| main_src | input | 17 | Main request lines, active high |
| per_src | input | 22 | Peripheral request lines, active high |
| reg_wr | input | 1 | Mask write strobe |
| reg_sel | input | 1 | Mask select: 0 main, 1 peripheral |
| reg_wdata | input | 32 | Mask write data |
| reg_rdata | output | 32 | Selected mask, combinational read |
| stat_word | output | 32 | Registered encoded status word |

## Verification
On every cycle the assertions check the following: bits outside the fields stay at zero, idle groups report source 0, unimplemented mask bits read zero, and the unmaskable critical line 0 and peripheral source 0 win on the next cycle. They also check that the ignored critical line 2 cannot by itself raise the critical flag. Only the bench scenarios can show the rest. These are the full priority order under changing masks, and the mapping from mask bit position to source. They also cover the forwarding of peripheral requests into critical code 2 and main code 4, and the one-cycle latency of a mask write.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;
   localparam int CRIT_VLD = 10;
   localparam int CRIT_LSB = 8;
   localparam int CRIT_W   = 2;
   localparam int MAIN_VLD = 21;
   localparam int MAIN_LSB = 16;
   localparam int MAIN_W   = 5;
   localparam int PER_VLD  = 29;
   localparam int PER_LSB  = 24;
   localparam int PER_W    = 5;
   localparam int MAIN_MTOP = 16;
   localparam int PER_MTOP  = 31;
   localparam int CRIT_ALIAS = 2;
   localparam int MAIN_ALIAS = 4;
   localparam logic [31:0] FIELD_MASK = 32'h3F3F_0700;

   typedef enum logic {
      SEL_MAIN = 1'b0,
      SEL_PER  = 1'b1
   } mask_sel_e;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int N = 4,
   parameter int W = 2
) (
   input  logic [N-1:0] req,
   output logic         valid,
   output logic [W-1:0] idx
);
   if (N > (1 << W)) begin : g_bad_w
      $error("irq_lowest_pick: N does not fit in W bits");
   end

   always_comb begin
      valid = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter logic [31:0] IMPL = 32'h0000_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [31:0] wdata,
   output logic [31:0] mask
);
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   for (genvar b = 0; b < 32; b++) begin : g_bit
      if (IMPL[b]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  mask[b] <= 1'b1;
            else if (wr) mask[b] <= wdata[b];
         end
      end else begin : g_tie
         assign mask[b] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_alias_route.sv
module irq_alias_route #(
   parameter int          N_CRIT = 4,
   parameter int          N_MAIN = 17,
   parameter int          N_PER  = 22,
   parameter logic [31:0] HI_SET = 32'h0000_0006
) (
   input  logic [N_CRIT-1:0] crit_src,
   input  logic [N_MAIN-1:0] main_act,
   input  logic [N_PER-1:0]  per_act,
   output logic [N_CRIT-1:0] crit_vec,
   output logic [N_MAIN-1:0] main_vec
);
   import irqenc_pkg::*;

   localparam logic [N_PER-1:0] HI = HI_SET[N_PER-1:0];

   logic hp_any;
   logic lp_any;

   assign hp_any = |(per_act & HI);
   assign lp_any = |(per_act & ~HI);

   always_comb begin
      crit_vec             = crit_src;
      crit_vec[CRIT_ALIAS] = hp_any;
      main_vec             = main_act;
      main_vec[MAIN_ALIAS] = lp_any;
   end
endmodule

// File: rtl/irq_status_enc.sv
module irq_status_enc #(
   parameter int          N_CRIT     = 4,
   parameter int          N_MAIN     = 17,
   parameter int          N_PER      = 22,
   parameter logic [31:0] MMASK_IMPL = 32'h0001_0fff,
   parameter logic [31:0] PMASK_IMPL = 32'h7fff_fc00,
   parameter logic [31:0] PER_HI_SET = 32'h0000_0006
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CRIT-1:0] crit_src,
   input  logic [N_MAIN-1:0] main_src,
   input  logic [N_PER-1:0]  per_src,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [31:0]       stat_word
);
   import irqenc_pkg::*;

   if (N_CRIT <= CRIT_ALIAS || N_CRIT > (1 << CRIT_W)) begin : g_chk_crit
      $error("irq_status_enc: N_CRIT out of range");
   end
   if (N_MAIN <= MAIN_ALIAS || N_MAIN > MAIN_MTOP + 1) begin : g_chk_main
      $error("irq_status_enc: N_MAIN out of range");
   end
   if (N_PER < 1 || N_PER > PER_MTOP + 1) begin : g_chk_per
      $error("irq_status_enc: N_PER out of range");
   end

   logic [31:0] mmask, pmask;
   logic        wr_main, wr_per;
   logic        unused_mask;

   assign wr_main     = reg_wr && (mask_sel_e'(reg_sel) == SEL_MAIN);
   assign wr_per      = reg_wr && (mask_sel_e'(reg_sel) == SEL_PER);
   assign unused_mask = ^{mmask, pmask};

   irq_mask_bank #(.IMPL(MMASK_IMPL)) u_mmask (
      .clk(clk), .rst_n(rst_n), .wr(wr_main), .wdata(reg_wdata), .mask(mmask)
   );
   irq_mask_bank #(.IMPL(PMASK_IMPL)) u_pmask (
      .clk(clk), .rst_n(rst_n), .wr(wr_per), .wdata(reg_wdata), .mask(pmask)
   );

   assign reg_rdata = (mask_sel_e'(reg_sel) == SEL_PER) ? pmask : mmask;

   logic [N_MAIN-1:0] main_en;
   logic [N_PER-1:0]  per_en;

   for (genvar n = 0; n < N_MAIN; n++) begin : g_men
      assign main_en[n] = ~mmask[MAIN_MTOP-n];
   end
   for (genvar n = 0; n < N_PER; n++) begin : g_pen
      assign per_en[n] = ~pmask[PER_MTOP-n];
   end

   logic [N_MAIN-1:0] main_act;
   logic [N_PER-1:0]  per_act;
   logic [N_CRIT-1:0] crit_vec;
   logic [N_MAIN-1:0] main_vec;

   assign main_act = main_src & main_en;
   assign per_act  = per_src & per_en;

   irq_alias_route #(
      .N_CRIT(N_CRIT), .N_MAIN(N_MAIN), .N_PER(N_PER), .HI_SET(PER_HI_SET)
   ) u_route (
      .crit_src(crit_src), .main_act(main_act), .per_act(per_act),
      .crit_vec(crit_vec), .main_vec(main_vec)
   );

   logic              c_vld, m_vld, p_vld;
   logic [CRIT_W-1:0] c_idx;
   logic [MAIN_W-1:0] m_idx;
   logic [PER_W-1:0]  p_idx;

   irq_lowest_pick #(.N(N_CRIT), .W(CRIT_W)) u_pick_crit (
      .req(crit_vec), .valid(c_vld), .idx(c_idx)
   );
   irq_lowest_pick #(.N(N_MAIN), .W(MAIN_W)) u_pick_main (
      .req(main_vec), .valid(m_vld), .idx(m_idx)
   );
   irq_lowest_pick #(.N(N_PER), .W(PER_W)) u_pick_per (
      .req(per_act), .valid(p_vld), .idx(p_idx)
   );

   logic [31:0] stat_d;

   always_comb begin
      stat_d                         = '0;
      stat_d[CRIT_VLD]               = c_vld;
      stat_d[CRIT_LSB +: CRIT_W]     = c_idx;
      stat_d[MAIN_VLD]               = m_vld;
      stat_d[MAIN_LSB +: MAIN_W]     = m_idx;
      stat_d[PER_VLD]                = p_vld;
      stat_d[PER_LSB +: PER_W]       = p_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_word <= '0;
      else        stat_word <= stat_d;
   end
endmodule

// File: rtl/irq_status_enc_chk.sv
module irq_status_enc_chk #(
   parameter int          N_CRIT     = 4,
   parameter int          N_PER      = 22,
   parameter logic [31:0] MMASK_IMPL = 32'h0001_0fff,
   parameter logic [31:0] PMASK_IMPL = 32'h7fff_fc00
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_CRIT-1:0] crit_src,
   input logic [N_PER-1:0]  per_src,
   input logic              reg_sel,
   input logic [31:0]       reg_rdata,
   input logic [31:0]       stat_word
);
   import irqenc_pkg::*;

   localparam logic [N_CRIT-1:0] CRIT_REAL = ~(N_CRIT'(1) << CRIT_ALIAS);

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_word & ~FIELD_MASK) == 32'h0); // R7
   AST_CRIT0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      crit_src[0] |=> (stat_word[CRIT_VLD] && stat_word[9:8] == 2'd0)); // R2
   AST_PER0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      per_src[0] |=> (stat_word[PER_VLD] && stat_word[28:24] == 5'd0)); // R4
   AST_CRIT_LINE2_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ((crit_src & CRIT_REAL) == '0 && per_src == '0) |=> !stat_word[CRIT_VLD]); // R5
   AST_IDLE_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_word[CRIT_VLD] |-> stat_word[9:8] == 2'd0); // R9
   AST_IDLE_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_word[MAIN_VLD] |-> stat_word[20:16] == 5'd0); // R9
   AST_IDLE_PER: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_word[PER_VLD] |-> stat_word[28:24] == 5'd0); // R9
   AST_MMASK_UNIMPL: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> (reg_rdata & ~MMASK_IMPL) == 32'h0); // R8
   AST_PMASK_UNIMPL: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel |-> (reg_rdata & ~PMASK_IMPL) == 32'h0); // R8
endmodule

bind irq_status_enc irq_status_enc_chk #(
   .N_CRIT(N_CRIT), .N_PER(N_PER), .MMASK_IMPL(MMASK_IMPL), .PMASK_IMPL(PMASK_IMPL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .crit_src(crit_src), .per_src(per_src),
   .reg_sel(reg_sel), .reg_rdata(reg_rdata), .stat_word(stat_word)
);

// File: tb/test_irq_status_enc.sv
module test_irq_status_enc;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  crit_src;
   logic [16:0] main_src;
   logic [21:0] per_src;
   logic        reg_wr;
   logic        reg_sel;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic [31:0] stat_word;

   always #10 clk = ~clk;

   irq_status_enc i_irq_status_enc (
      .clk(clk), .rst_n(rst_n), .crit_src(crit_src), .main_src(main_src),
      .per_src(per_src), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_word(stat_word)
   );

   int          checks = 0;
   int          errors = 0;
   bit          done   = 0;
   logic [31:0] mm_m, pm_m;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   localparam logic [31:0] MIMPL = 32'h0001_0fff;
   localparam logic [31:0] PIMPL = 32'h7fff_fc00;
   localparam logic [21:0] HI    = 22'h000006;

   function automatic logic [31:0] model(logic [3:0] c, logic [16:0] m, logic [21:0] p);
      logic [21:0] pv;
      logic [16:0] mv;
      logic [3:0]  cv;
      logic [31:0] r;
      r = 32'h0;
      for (int n = 0; n < 22; n++) pv[n] = p[n] & ~pm_m[31-n];
      for (int n = 0; n < 17; n++) mv[n] = m[n] & ~mm_m[16-n];
      mv[4] = |(pv & ~HI);
      cv    = c;
      cv[2] = |(pv & HI);
      for (int n = 3; n >= 0; n--) if (cv[n]) begin r[10] = 1'b1; r[9:8] = 2'(n); end
      for (int n = 16; n >= 0; n--) if (mv[n]) begin r[21] = 1'b1; r[20:16] = 5'(n); end
      for (int n = 21; n >= 0; n--) if (pv[n]) begin r[29] = 1'b1; r[28:24] = 5'(n); end
      return r;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic drive(logic [3:0] c, logic [16:0] m, logic [21:0] p, string tag);
      @(negedge clk);
      crit_src = c; main_src = m; per_src = p;
      exp_q.push_back(model(c, m, p));
      tag_q.push_back(tag);
   endtask

   task automatic wr_mask(logic sel, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (sel) pm_m = d & PIMPL; else mm_m = d & MIMPL;
   endtask

   task automatic rd_check(logic sel, logic [31:0] exp, string tag);
      @(negedge clk);
      reg_sel = sel;
      #1 check(tag, reg_rdata, exp);
   endtask

   task automatic drain;
      @(posedge clk);
      #6;
   endtask

   // monitor: pops one expected word per edge, after the edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, stat_word, e);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; crit_src = '0; main_src = '0; per_src = '0;
      reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
      mm_m = MIMPL; pm_m = PIMPL;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1 check("R1 status after reset", stat_word, 32'h0);
      rd_check(1'b0, 32'h0001_0fff, "R1 main mask reset");
      rd_check(1'b1, 32'h7fff_fc00, "R1 per mask reset");

      drive(4'b0100, '0, '0, "R5 crit line 2 ignored");
      drive(4'b1000, '0, '0, "R2 crit line 3");
      @(negedge clk);
      crit_src = 4'b0011;
      #1 check("R7 output held until edge", stat_word, 32'h0000_0700);
      exp_q.push_back(model(4'b0011, '0, '0));
      tag_q.push_back("R2 crit lowest wins");
      drive('0, 17'h00010, '0, "R6 main line 4 ignored");
      drive('0, 17'h1fff1, '0, "R3 masked main sources, unmaskable 1..3 absent");
      drive('0, 17'h0000c, '0, "R3 unmaskable main 2");
      drive('0, '0, 22'h000001, "R4 R6 DMA cascade unmaskable");
      drive('0, '0, 22'h000002, "R4 masked peripheral 1");
      drain();

      wr_mask(1'b1, 32'hffff_ffff);
      rd_check(1'b1, 32'h7fff_fc00, "R8 per mask unimpl bits ignore writes");
      wr_mask(1'b1, 32'h0);
      rd_check(1'b1, 32'h0, "R8 per mask cleared");
      wr_mask(1'b0, 32'hffff_0000);
      rd_check(1'b0, 32'h0001_0000, "R8 main mask unimpl bits");

      drive('0, '0, 22'h000002, "R5 high-priority peripheral alias");
      drive('0, '0, 22'h200020, "R6 low-priority peripheral alias");
      drive('0, '0, 22'h000006, "R5 high set only, no main alias");
      drive('0, '0, 22'h200000, "R4 peripheral 21");
      drain();

      wr_mask(1'b0, 32'h0);
      drive('0, 17'h10200, '0, "R3 main lowest enabled wins");
      drain();
      wr_mask(1'b0, 32'h0000_0080);
      drive('0, 17'h10200, '0, "R3 main mask bit 7 hides source 9");
      drive('0, 17'h10201, '0, "R3 main source 0 enabled");
      drain();
      wr_mask(1'b0, 32'h0001_0000);
      drive('0, 17'h00001, '0, "R3 main source 0 masked by bit 16");
      drive(4'b1111, 17'h1ffff, 22'h3fffff, "R2 R3 R4 all active");
      drain();

      for (int k = 0; k < 300; k++) begin
         if (k % 25 == 0) begin
            drain();
            wr_mask(1'b0, $urandom);
            wr_mask(1'b1, $urandom);
         end
         drive(4'($urandom), 17'($urandom), 22'($urandom & $urandom),
               "R2 R3 R4 R5 R6 R9 random");
      end
      drain();
      drain();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule